// File: doc/BRIEF.md
# Programmable Parallel Port Core

This block hangs off a small processor's byte-wide bus and gives it three 8-bit parallel ports, called A, B and C. Port C is split into an upper and a lower nibble. Port A and the upper nibble form group A. Port B and the lower nibble form group B. Each port, or each half of port C, can be made an input or an output. Output values are held in latches. Input pins are read live, with no latch.

A single control register sets how the ports behave. A control write with its top bit set is a configuration word. It sets the direction of each group and the handshake mode fields. A control write with its top bit clear is a single-bit command. It sets or clears one port C latch bit and leaves the configuration alone. Only plain, unhandshaked I/O is built here. The decoded handshake mode of each group is driven out on configuration pins so that neighbouring logic can act on it.

Top module: `pio_core`

## Requirements
- R1: After reset every output enable is low, every output latch is 0, both mode outputs are 0, and a read of the control register returns 0x9B (all ports input, plain mode).
- R2: Register select is addr=0 port A, addr=1 port B, addr=2 port C, addr=3 control. A write with cs_n and wr_n low on a clock edge loads the selected port's output latch, which appears on that port's `_out` pins from the next cycle.
- R3: A control write with bit 7 = 1 sets the directions, with 1 meaning input: bit 4 for port A, bit 3 for port C bits 7:4, bit 1 for port B and bit 0 for port C bits 3:0. An output enable is high exactly when its direction bit is 0.
- R4: After a configuration word, `grp_a_mode` is 0 when bits 6:5 = 00, 1 when they are 01, and 2 when bit 6 = 1. `grp_b_mode` equals bit 2.
- R5: A configuration write clears all output latches of A, B and C.
- R6: A control write with bit 7 = 0 sets port C latch bit number bits 3:1 to the value of bit 0. The other port C latch bits keep their values, and bits 6:4 of the word have no effect.
- R7: A bit command leaves the stored configuration unchanged: the control readback, the output enables and the mode outputs all stay as they were.
- R8: A read of an output port, or of an output half of port C, returns the latch. A read of an input port or half returns the live pin value of the same cycle.
- R9: `dout` is 0 unless both cs_n and rd_n are low.
- R10: While cs_n is high, wr_n has no effect on any latch or on the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, sampled each clock |
| addr | input | 2 | Register select |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not reading |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C output enables, per bit |
| grp_a_mode | output | 2 | Decoded group A handshake mode |
| grp_b_mode | output | 1 | Decoded group B handshake mode |

## Verification
Random configuration words cover all sixteen direction combinations. When they are mixed with port writes, a swapped direction bit or a wrong nibble split in port C shows up as an output enable or readback mismatch. Bit commands carry random values in bits 6:4. A decoder that reads the ignored bits, or that disturbs neighbouring bits, then changes the port C latch. Pins change between reads with no strobe, which separates a live input read from a latched one. Directed cases cover reset, writes made with the chip unselected, reads while idle, and the 10/11 mode encodings.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] RESET_WORD = 8'h9B;

  typedef enum logic [1:0] {SEL_A = 2'd0, SEL_B = 2'd1, SEL_C = 2'd2, SEL_CTRL = 2'd3} reg_sel_e;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       b_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  // Decode a stored configuration word into its fields.
  function automatic cfg_t cfg_decode(logic [DW-1:0] w);
    cfg_t c;
    c.a_mode = w[6] ? 2'd2 : (w[5] ? 2'd1 : 2'd0);
    c.b_mode = w[2];
    c.a_in   = w[4];
    c.cu_in  = w[3];
    c.b_in   = w[1];
    c.cl_in  = w[0];
    return c;
  endfunction

  // Per-bit read mux: latch where driving, pin where receiving.
  function automatic logic [DW-1:0] read_mix(logic [DW-1:0] lat, logic [DW-1:0] pin,
                                             logic [DW-1:0] oe);
    return (lat & oe) | (pin & ~oe);
  endfunction
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_word,
  output cfg_t          cfg,
  output logic          mode_wr,
  output logic          sr_wr,
  output logic [2:0]    sr_idx,
  output logic          sr_val
);
  logic [DW-1:0] word_q;

  assign mode_wr = wr_ctrl & wdata[DW-1];
  assign sr_wr   = wr_ctrl & ~wdata[DW-1];
  assign sr_idx  = wdata[3:1];
  assign sr_val  = wdata[0];

  always_ff @(posedge clk) begin
    if (rst)          word_q <= RESET_WORD;
    else if (mode_wr) word_q <= wdata;
  end

  assign ctrl_word = word_q;
  assign cfg       = cfg_decode(word_q);

  AST_MODE_LOADS: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> ctrl_word == $past(wdata)); // R3
  AST_SR_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
    sr_wr |=> $stable(ctrl_word)); // R7
  AST_WORD_TOP_SET: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[DW-1]); // R1
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  input  logic          sr_en,
  input  logic [IW-1:0] sr_idx,
  input  logic          sr_val,
  input  logic          dir_in,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  lat,
  output logic [W-1:0]  oe,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  lat_q <= '0;
    else if (wr_en)  lat_q <= wdata;
    else if (sr_en)  lat_q[sr_idx] <= sr_val;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign oe[i]    = ~dir_in;
    assign rdata[i] = oe[i] ? lat_q[i] : pin_in[i];
  end

  assign lat = lat_q;

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> lat == '0); // R5
  AST_SR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (sr_en && !wr_en && !clr) |=> $countones(lat ^ $past(lat)) <= 1); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !sr_en && !clr) |=> $stable(lat)); // R10
endmodule

// File: rtl/pio_core.sv
module pio_core
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe,
  output logic [1:0] grp_a_mode,
  output logic       grp_b_mode
);
  localparam int HW = DW / 2;

  logic          bus_wr, bus_rd;
  reg_sel_e      sel;
  logic [DW-1:0] ctrl_word;
  cfg_t          cfg;
  logic          mode_wr, sr_wr, sr_val;
  logic [2:0]    sr_idx;
  logic [DW-1:0] ra, rb;
  logic [HW-1:0] rcl, rcu;

  assign sel    = reg_sel_e'(addr);
  assign bus_wr = ~cs_n & ~wr_n;
  assign bus_rd = ~cs_n & ~rd_n;

  pio_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(bus_wr && sel == SEL_CTRL), .wdata(din),
    .ctrl_word(ctrl_word), .cfg(cfg), .mode_wr(mode_wr), .sr_wr(sr_wr),
    .sr_idx(sr_idx), .sr_val(sr_val)
  );

  pio_port #(.W(DW)) u_pa (
    .clk(clk), .rst(rst), .clr(mode_wr), .wr_en(bus_wr && sel == SEL_A), .wdata(din),
    .sr_en(1'b0), .sr_idx('0), .sr_val(1'b0), .dir_in(cfg.a_in), .pin_in(pa_in),
    .lat(pa_out), .oe(pa_oe), .rdata(ra)
  );

  pio_port #(.W(DW)) u_pb (
    .clk(clk), .rst(rst), .clr(mode_wr), .wr_en(bus_wr && sel == SEL_B), .wdata(din),
    .sr_en(1'b0), .sr_idx('0), .sr_val(1'b0), .dir_in(cfg.b_in), .pin_in(pb_in),
    .lat(pb_out), .oe(pb_oe), .rdata(rb)
  );

  pio_port #(.W(HW)) u_pcl (
    .clk(clk), .rst(rst), .clr(mode_wr), .wr_en(bus_wr && sel == SEL_C),
    .wdata(din[HW-1:0]), .sr_en(sr_wr && !sr_idx[2]), .sr_idx(sr_idx[1:0]),
    .sr_val(sr_val), .dir_in(cfg.cl_in), .pin_in(pc_in[HW-1:0]),
    .lat(pc_out[HW-1:0]), .oe(pc_oe[HW-1:0]), .rdata(rcl)
  );

  pio_port #(.W(HW)) u_pcu (
    .clk(clk), .rst(rst), .clr(mode_wr), .wr_en(bus_wr && sel == SEL_C),
    .wdata(din[DW-1:HW]), .sr_en(sr_wr && sr_idx[2]), .sr_idx(sr_idx[1:0]),
    .sr_val(sr_val), .dir_in(cfg.cu_in), .pin_in(pc_in[DW-1:HW]),
    .lat(pc_out[DW-1:HW]), .oe(pc_oe[DW-1:HW]), .rdata(rcu)
  );

  always_comb begin
    dout = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_A:    dout = ra;
        SEL_B:    dout = rb;
        SEL_C:    dout = {rcu, rcl};
        SEL_CTRL: dout = ctrl_word;
      endcase
    end
  end

  assign grp_a_mode = cfg.a_mode;
  assign grp_b_mode = cfg.b_mode;

  AST_UNSEL_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable({pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe})); // R10
  AST_SR_KEEPS_OE: assert property (@(posedge clk) disable iff (rst)
    sr_wr |=> $stable({pa_oe, pb_oe, pc_oe, grp_a_mode, grp_b_mode})); // R7
  AST_MODE_2_RANGE: assert property (@(posedge clk) disable iff (rst)
    grp_a_mode != 2'd3); // R4
  AST_READ_MIX: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_C) |-> dout == read_mix(pc_out, pc_in, pc_oe)); // R8
endmodule

// File: tb/pio_core_bench.sv
module pio_core_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0, pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [1:0] grp_a_mode;
  logic grp_b_mode;

  int vectors = 0, errors = 0;
  logic [7:0] m_ctrl = 8'h9B, m_a = '0, m_b = '0, m_c = '0;

  always #2 clk = ~clk;

  pio_core u_pio_core (.*);

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  function automatic logic [7:0] oe_of(logic [7:0] w, int port);
    case (port)
      0: return w[4] ? 8'h00 : 8'hFF;
      1: return w[1] ? 8'h00 : 8'hFF;
      default: return {w[3] ? 4'h0 : 4'hF, w[0] ? 4'h0 : 4'hF};
    endcase
  endfunction

  function automatic logic [1:0] amode_of(logic [7:0] w);
    if (w[6]) return 2'd2;
    return w[5] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [7:0] exp_read(logic [1:0] a);
    logic [7:0] o;
    case (a)
      2'd0: begin o = oe_of(m_ctrl, 0); return (m_a & o) | (pa_in & ~o); end
      2'd1: begin o = oe_of(m_ctrl, 1); return (m_b & o) | (pb_in & ~o); end
      2'd2: begin o = oe_of(m_ctrl, 2); return (m_c & o) | (pc_in & ~o); end
      default: return m_ctrl;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    case (a)
      2'd0: m_a = d;
      2'd1: m_b = d;
      2'd2: m_c = d;
      default:
        if (d[7]) begin m_ctrl = d; m_a = '0; m_b = '0; m_c = '0; end
        else m_c[d[3:1]] = d[0];
    endcase
  endtask

  task automatic bus_rd(logic [1:0] a, string req);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
    chk(req, dout, exp_read(a));
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic chk_pins(string req);
    chk({req, " pa_out"}, pa_out, m_a);
    chk({req, " pb_out"}, pb_out, m_b);
    chk({req, " pc_out"}, pc_out, m_c);
    chk({req, " pa_oe"}, pa_oe, oe_of(m_ctrl, 0));
    chk({req, " pb_oe"}, pb_oe, oe_of(m_ctrl, 1));
    chk({req, " pc_oe"}, pc_oe, oe_of(m_ctrl, 2));
    chk({req, " modes"}, {5'd0, grp_a_mode, grp_b_mode}, {5'd0, amode_of(m_ctrl), m_ctrl[2]});
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_pins("R1 reset");
    bus_rd(2'd3, "R1 ctrl readback");

    // R3/R2: all outputs, then write each port
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'hA5); bus_wr(2'd1, 8'h3C); bus_wr(2'd2, 8'h96);
    chk_pins("R2 latches");
    bus_rd(2'd0, "R2 read A"); bus_rd(2'd2, "R8 read C out");

    // R5: new configuration clears latches
    bus_wr(2'd3, 8'h80);
    chk_pins("R5 clear");

    // R6: bit command with junk in bits 6:4
    bus_wr(2'd2, 8'h0F);
    bus_wr(2'd3, 8'h7F);
    bus_wr(2'd3, 8'h50);
    chk_pins("R6 bit command");
    bus_wr(2'd3, 8'h8F);
    bus_wr(2'd3, 8'h0B);
    chk_pins("R7 config kept");
    bus_rd(2'd3, "R7 ctrl after bit cmd");

    // R4: mode encodings 10 and 11
    bus_wr(2'd3, 8'hC4); chk_pins("R4 mode 10");
    bus_wr(2'd3, 8'hE0); chk_pins("R4 mode 11");
    bus_wr(2'd3, 8'hA2); chk_pins("R4 mode 01");

    // R8: live input pins, mixed C halves
    bus_wr(2'd3, 8'h98);
    pa_in = 8'h11; pc_in = 8'hC3; bus_rd(2'd0, "R8 live A");
    pa_in = 8'h77; bus_rd(2'd0, "R8 live A changed");
    bus_wr(2'd2, 8'h5A); bus_rd(2'd2, "R8 mixed C");

    // R9: idle read bus
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1; chk("R9 idle cs", dout, 8'h00);
    rd_n = 1'b1; cs_n = 1'b0; #1; chk("R9 idle rd", dout, 8'h00); cs_n = 1'b1;

    // R10: write strobe without select
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b0; addr = 2'd3; din = 8'h80;
    @(negedge clk); wr_n = 1'b0; addr = 2'd2; din = 8'hFF;
    @(negedge clk); wr_n = 1'b1;
    chk_pins("R10 unselected");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      if (a == 2'd3 && $urandom_range(0, 2) == 0) d[7] = 1'b1;
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      bus_wr(a, d);
      chk_pins(d[7] ? "R3 random cfg" : "R6 random");
      bus_rd(2'($urandom_range(0, 3)), "R8 random read");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule